// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind the bus port of a byte-wide parallel NOR flash model and turns sequences of bus write cycles into requests for an internal program/erase engine. Each write cycle is framed by an active-low write strobe. The address is captured when the strobe falls, and the data byte is taken when it rises. Every command starts with two address-qualified unlock writes. The sequencer recognises byte program, chip erase, sector erase with several sectors loaded inside a timed window, erase suspend and resume, silicon-ID entry and the reset command. It also tells the read path which source to return: array, ID or status.

Requests go out as a one-cycle `op_valid` pulse with an opcode, address, data and sector mask. The engine reports that its work is finished with a one-cycle `eng_done` pulse. The sectors have a uniform size, and the top address bits select the sector. The load window lasts `WINDOW_US` microseconds, counted in clock cycles at `CLK_MHZ`.

The FSM states are as follows. `ST_READ` is idle. `ST_UNLK1` and `ST_UNLK2` follow the first and second unlock writes. `ST_PROG_ARM` waits for the program target. `ST_ERS_SETUP`, `ST_ERS_UNLK1` and `ST_ERS_UNLK2` cover the erase setup and its second unlock pair. `ST_SECT_LOAD` is the load window. The other states are `ST_ERASING`, `ST_SUSPENDED`, `ST_PROG_BUSY` and `ST_ID`.

The transitions are as follows:
- A valid unlock write advances to the next unlock or setup state.
- A0h arms a program, and the next write issues it.
- 80h leads to erase setup.
- 10h at 555h issues a chip erase.
- 30h at a sector address opens the load window. Each further 30h reloads the window, and when the window expires the sector erase is issued.
- B0h suspends an erase and 30h resumes it.
- 90h enters ID mode, and any write leaves it.
- `eng_done` ends a busy state.
- Any out-of-sequence write falls back to idle. Idle is `ST_SUSPENDED` while a suspend is in force and `ST_READ` otherwise.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset is released, `rd_mode` is 0 (array) and `op_valid` is 0. Asserting `rst_n` at any time, including during an erase, returns the sequencer to array read, and later `eng_done` pulses or B0h writes issue nothing.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by a write of D@A issue one request with `op_code`=1, address A, data D and mask 0. `rd_mode` is 2 (status) until `eng_done`, after which it is 0.
- R3: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h issues `op_code`=2 with every mask bit set. `rd_mode` is 2 until `eng_done`.
- R4: Replacing the final write of R3 with 30h at a sector address starts a window of `CLK_MHZ*WINDOW_US` cycles. Each further 30h write inside the window adds its sector and restarts the window. When the window expires, `op_code`=3 is issued with mask bit s set for every loaded sector s (s = top address bits), and not before.
- R5: A write that breaks an unlock or setup sequence issues nothing and leaves `rd_mode` at 0.
- R6: B0h written during an erase issues `op_code`=4 carrying the erase mask. While suspended, `rd_mode` is 2 for addresses in a sector being erased and 0 elsewhere. A later 30h write issues `op_code`=5 and status mode returns.
- R7: While suspended, a full program sequence to a sector not being erased issues `op_code`=1 and returns to the suspended state after `eng_done`. A program to a sector being erased is dropped with no request.
- R8: 90h after the unlock pair gives `rd_mode`=1 (ID). `id_data` is C2h for address bits [1:0]=00, and 36h (top-boot build) or 37h (bottom-boot build) for 01. Any write then returns to `rd_mode`=0.
- R9: The request address is the address present when the strobe fell, even if the bus address changes before the strobe rises. The data is the byte present when it rises.
- R10: A write other than 30h during the sector load window cancels the erase with no request and `rd_mode` 0.
- R11: `op_valid` never stays high for two consecutive cycles. An `eng_done` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we_n | input | 1 | Active-low write strobe |
| bus_addr | input | ADDR_W | Bus address (write and read) |
| bus_data | input | 8 | Bus write data |
| eng_done | input | 1 | Engine finished pulse |
| op_valid | output | 1 | One-cycle request pulse |
| op_code | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Request address |
| op_data | output | 8 | Request data |
| op_mask | output | NUM_SECT | Sector mask of the request |
| rd_mode | output | 2 | Read source: 0 array, 1 ID, 2 status |
| id_data | output | 8 | Silicon-ID byte for the current bus address |

## Verification
A wrong internal state is visible at the ports almost at once. A mis-stepped unlock state shows up as a request that is missing, extra or wrongly coded in the cycle after the strobe rises. A stale suspend flag or mask shows up in `rd_mode` the moment the bus address moves into or out of an erasing sector. A window counter that is off changes when the sector erase request arrives relative to the last load, so the bench brackets that moment from both sides. The reset and cancel paths are checked by watching for requests that must never arrive.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG_ARM,
        ST_ERS_SETUP,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_SECT_LOAD,
        ST_ERASING,
        ST_SUSPENDED,
        ST_PROG_BUSY,
        ST_ID
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_SUSPEND    = 3'd4,
        OP_RESUME     = 3'd5
    } op_code_t;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_ID     = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_t;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_ID       = 8'h90;

    localparam logic [11:0] ADR_FIRST  = 12'h555;
    localparam logic [11:0] ADR_SECOND = 12'h2AA;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              we_q;
    logic [ADDR_W-1:0] addr_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            addr_lat <= '0;
        end else begin
            we_q <= we_n;
            if (we_q && !we_n)
                addr_lat <= bus_addr;
        end
    end

    assign wr_evt  = !we_q && we_n;
    assign wr_addr = addr_lat;
    assign wr_data = bus_data;
endmodule

// File: rtl/flash_load_window.sv
module flash_load_window #(
    parameter int WIN_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= RELOAD;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = run && !restart && (cnt == '0);
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode #(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [1:0] sel,
    output logic [7:0] id_data
);
    localparam logic [7:0] MAKER_CODE = 8'hC2;
    localparam logic [7:0] PART_CODE  = TOP_BOOT ? 8'h36 : 8'h37;

    always_comb begin
        unique case (sel)
            2'b00:   id_data = MAKER_CODE;
            2'b01:   id_data = PART_CODE;
            default: id_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int NUM_SECT  = 8,
    parameter int CLK_MHZ   = 100,
    parameter int WINDOW_US = 30,
    parameter bit TOP_BOOT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_data,
    input  logic                eng_done,
    output logic                op_valid,
    output logic [2:0]          op_code,
    output logic [ADDR_W-1:0]   op_addr,
    output logic [7:0]          op_data,
    output logic [NUM_SECT-1:0] op_mask,
    output logic [1:0]          rd_mode,
    output logic [7:0]          id_data
);
    localparam int SECT_BITS  = $clog2(NUM_SECT);
    localparam int WIN_CYCLES = CLK_MHZ * WINDOW_US;
    localparam int UNLK_W     = 12;

    logic              wr_evt;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              win_restart, win_run, win_expired;

    flash_bus_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr),
        .bus_data(bus_data), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_load_window #(.WIN_CYCLES(WIN_CYCLES)) win_i (
        .clk(clk), .rst_n(rst_n), .restart(win_restart), .run(win_run),
        .expired(win_expired)
    );

    flash_id_decode #(.TOP_BOOT(TOP_BOOT)) id_i (
        .sel(bus_addr[1:0]), .id_data(id_data)
    );

    seq_state_t          state, nxt;
    logic [NUM_SECT-1:0] sect_mask, mask_nxt;
    logic                in_susp, susp_nxt;
    logic                issue;
    op_code_t            code_nxt;
    logic [ADDR_W-1:0]   addr_nxt;
    logic [7:0]          data_nxt;
    logic [NUM_SECT-1:0] omask_nxt;

    logic [SECT_BITS-1:0] wr_sec, rd_sec;
    logic [NUM_SECT-1:0]  wr_onehot;
    logic                 at_first, at_second;
    seq_state_t           idle_st;

    assign wr_sec    = wr_addr[ADDR_W-1 -: SECT_BITS];
    assign rd_sec    = bus_addr[ADDR_W-1 -: SECT_BITS];
    assign wr_onehot = NUM_SECT'(1) << wr_sec;
    assign at_first  = (wr_addr[UNLK_W-1:0] == ADR_FIRST);
    assign at_second = (wr_addr[UNLK_W-1:0] == ADR_SECOND);
    assign idle_st   = in_susp ? ST_SUSPENDED : ST_READ;

    assign win_run     = (state == ST_SECT_LOAD);
    assign win_restart = wr_evt && (wr_data == CMD_SECTOR) &&
                         ((state == ST_SECT_LOAD) || (state == ST_ERS_UNLK2 && !at_first) ||
                          (state == ST_ERS_UNLK2 && at_first));

    // next state and request decode
    always_comb begin
        nxt       = state;
        mask_nxt  = sect_mask;
        susp_nxt  = in_susp;
        issue     = 1'b0;
        code_nxt  = OP_NONE;
        addr_nxt  = '0;
        data_nxt  = '0;
        omask_nxt = '0;
        unique case (state)
            ST_READ: begin
                if (wr_evt && wr_data == CMD_UNLOCK_A && at_first)
                    nxt = ST_UNLK1;
            end
            ST_UNLK1: begin
                if (wr_evt)
                    nxt = (wr_data == CMD_UNLOCK_B && at_second) ? ST_UNLK2 : idle_st;
            end
            ST_UNLK2: begin
                if (wr_evt) begin
                    nxt = idle_st;
                    if (at_first) begin
                        if (wr_data == CMD_PROGRAM)
                            nxt = ST_PROG_ARM;
                        else if (wr_data == CMD_ERASE && !in_susp)
                            nxt = ST_ERS_SETUP;
                        else if (wr_data == CMD_ID && !in_susp)
                            nxt = ST_ID;
                    end
                end
            end
            ST_PROG_ARM: begin
                if (wr_evt) begin
                    if (in_susp && sect_mask[wr_sec]) begin
                        nxt = ST_SUSPENDED;
                    end else begin
                        nxt      = ST_PROG_BUSY;
                        issue    = 1'b1;
                        code_nxt = OP_PROGRAM;
                        addr_nxt = wr_addr;
                        data_nxt = wr_data;
                    end
                end
            end
            ST_ERS_SETUP: begin
                if (wr_evt)
                    nxt = (wr_data == CMD_UNLOCK_A && at_first) ? ST_ERS_UNLK1 : ST_READ;
            end
            ST_ERS_UNLK1: begin
                if (wr_evt)
                    nxt = (wr_data == CMD_UNLOCK_B && at_second) ? ST_ERS_UNLK2 : ST_READ;
            end
            ST_ERS_UNLK2: begin
                if (wr_evt) begin
                    if (wr_data == CMD_CHIP && at_first) begin
                        nxt       = ST_ERASING;
                        mask_nxt  = '1;
                        issue     = 1'b1;
                        code_nxt  = OP_CHIP_ERASE;
                        omask_nxt = '1;
                    end else if (wr_data == CMD_SECTOR) begin
                        nxt      = ST_SECT_LOAD;
                        mask_nxt = wr_onehot;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_SECT_LOAD: begin
                if (wr_evt) begin
                    if (wr_data == CMD_SECTOR)
                        mask_nxt = sect_mask | wr_onehot;
                    else
                        nxt = ST_READ;
                end else if (win_expired) begin
                    nxt       = ST_ERASING;
                    issue     = 1'b1;
                    code_nxt  = OP_SECT_ERASE;
                    omask_nxt = sect_mask;
                end
            end
            ST_ERASING: begin
                if (eng_done) begin
                    nxt = ST_READ;
                end else if (wr_evt && wr_data == CMD_SUSPEND) begin
                    nxt       = ST_SUSPENDED;
                    susp_nxt  = 1'b1;
                    issue     = 1'b1;
                    code_nxt  = OP_SUSPEND;
                    omask_nxt = sect_mask;
                end
            end
            ST_SUSPENDED: begin
                if (wr_evt) begin
                    if (wr_data == CMD_SECTOR) begin
                        nxt       = ST_ERASING;
                        susp_nxt  = 1'b0;
                        issue     = 1'b1;
                        code_nxt  = OP_RESUME;
                        omask_nxt = sect_mask;
                    end else if (wr_data == CMD_UNLOCK_A && at_first) begin
                        nxt = ST_UNLK1;
                    end
                end
            end
            ST_PROG_BUSY: begin
                if (eng_done)
                    nxt = idle_st;
            end
            ST_ID: begin
                if (wr_evt)
                    nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_READ;
            sect_mask <= '0;
            in_susp   <= 1'b0;
        end else begin
            state     <= nxt;
            sect_mask <= mask_nxt;
            in_susp   <= susp_nxt;
        end
    end

    // request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            op_mask  <= '0;
        end else begin
            op_valid <= issue;
            if (issue) begin
                op_code <= code_nxt;
                op_addr <= addr_nxt;
                op_data <= data_nxt;
                op_mask <= omask_nxt;
            end
        end
    end

    // read source selection
    always_comb begin
        unique case (state)
            ST_ERASING, ST_SECT_LOAD, ST_PROG_BUSY: rd_mode = RD_STATUS;
            ST_ID:                                  rd_mode = RD_ID;
            default: rd_mode = (in_susp && sect_mask[rd_sec]) ? RD_STATUS : RD_ARRAY;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int ADDR_W   = 18,
    parameter int NUM_SECT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                op_valid,
    input logic [2:0]          op_code,
    input logic [NUM_SECT-1:0] op_mask,
    input logic [1:0]          rd_mode,
    input logic [7:0]          id_data
);
    a_r1_array_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_mode == 2'd0 && !op_valid));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    a_r2_prog_status: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |-> rd_mode == 2'd2);

    a_r3_chip_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |-> (&op_mask));

    a_r4_sector_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |-> (op_mask != '0 && rd_mode == 2'd2));

    a_r6_suspend_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |-> $past(rd_mode) == 2'd2);

    a_r8_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd1 && bus_addr[1:0] == 2'b00) |-> id_data == 8'hC2);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .op_valid(op_valid),
    .op_code(op_code), .op_mask(op_mask), .rd_mode(rd_mode), .id_data(id_data)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int ADDR_W = 18;
    localparam int NSECT  = 8;
    localparam int WIN    = 4 * 30;

    typedef struct packed {
        logic [2:0]        code;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [NSECT-1:0]  mask;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_data = '0;
    logic              eng_done = 1'b0;
    logic              op_valid;
    logic [2:0]        op_code;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic [NSECT-1:0]  op_mask;
    logic [1:0]        rd_mode;
    logic [7:0]        id_data;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done_flag = 1'b0;
    exp_t q[$];
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .NUM_SECT(NSECT), .CLK_MHZ(4), .WINDOW_US(30),
                    .TOP_BOOT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .eng_done(eng_done), .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .op_mask(op_mask), .rd_mode(rd_mode), .id_data(id_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit glitch);
        @(negedge clk);
        bus_addr = a;
        we_n = 1'b0;
        @(negedge clk);
        if (glitch) bus_addr = ~a;
        bus_data = d;
        @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_op(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                             input logic [7:0] d, input logic [NSECT-1:0] m);
        exp_t e;
        e.code = c; e.addr = a; e.data = d; e.mask = m;
        q.push_back(e);
    endtask

    task automatic unlock();
        bus_write(18'h00555, 8'hAA, 1'b0);
        bus_write(18'h002AA, 8'h55, 1'b0);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_mode_at(input logic [ADDR_W-1:0] a, input string req, input int exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, rd_mode, exp);
    endtask

    // monitor: pops expected requests as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            if (op_valid && prev_valid) chk("R11 pulse width", 1, 0);
            if (op_valid) begin
                if (q.size() == 0) begin
                    chk("R5/R10/R12 unexpected request", op_code, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R2/R3/R4/R6/R7 op_code", op_code, e.code);
                    chk("R2/R7/R9 op_addr", op_addr, e.addr);
                    chk("R2/R7/R9 op_data", op_data, e.data);
                    chk("R3/R4/R6 op_mask", op_mask, e.mask);
                end
            end
        end
        prev_valid = op_valid;
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_mode", rd_mode, 0);
        chk("R1 op_valid", op_valid, 0);

        // R2 byte program
        unlock();
        bus_write(18'h00555, 8'hA0, 1'b0);
        expect_op(3'd1, 18'h01234, 8'h5A, '0);
        bus_write(18'h01234, 8'h5A, 1'b0);
        chk("R2 status while busy", rd_mode, 2);
        done_pulse();
        chk("R2 array after done", rd_mode, 0);

        // R5 broken sequences
        bus_write(18'h00555, 8'hAA, 1'b0);
        bus_write(18'h002AA, 8'h56, 1'b0);
        chk("R5 after bad second unlock", rd_mode, 0);
        unlock();
        bus_write(18'h00555, 8'h77, 1'b0);
        chk("R5 after bad command", rd_mode, 0);
        unlock();
        bus_write(18'h00555, 8'h80, 1'b0);
        bus_write(18'h00123, 8'hAA, 1'b0);
        chk("R5 bad erase unlock", rd_mode, 0);

        // R9 address taken at falling strobe
        unlock();
        bus_write(18'h00555, 8'hA0, 1'b0);
        expect_op(3'd1, 18'h03C0F, 8'h99, '0);
        bus_write(18'h03C0F, 8'h99, 1'b1);
        done_pulse();

        // R8 ID mode
        unlock();
        bus_write(18'h00555, 8'h90, 1'b0);
        chk("R8 id mode", rd_mode, 1);
        @(negedge clk); bus_addr = 18'h00000; #1;
        chk("R8 maker code", id_data, 8'hC2);
        @(negedge clk); bus_addr = 18'h00001; #1;
        chk("R8 part code", id_data, 8'h36);
        bus_write(18'h00000, 8'hF0, 1'b0);
        chk("R8 leave id", rd_mode, 0);

        // R11 stray done while idle
        done_pulse();
        chk("R11 stray done", rd_mode, 0);

        // R3 chip erase
        unlock();
        bus_write(18'h00555, 8'h80, 1'b0);
        unlock();
        expect_op(3'd2, '0, 8'h00, 8'hFF);
        bus_write(18'h00555, 8'h10, 1'b0);
        chk("R3 status during erase", rd_mode, 2);
        done_pulse();
        chk("R3 array after done", rd_mode, 0);

        // R4 sector erase with two loads
        unlock();
        bus_write(18'h00555, 8'h80, 1'b0);
        unlock();
        expect_op(3'd3, '0, 8'h00, 8'h24);
        bus_write(18'h10000, 8'h30, 1'b0);
        chk("R4 status in window", rd_mode, 2);
        repeat (60) @(negedge clk);
        bus_write(18'h28000, 8'h30, 1'b0);
        repeat (100) @(negedge clk);
        chk("R4 not before window end", q.size(), 1);
        repeat (40) @(negedge clk);
        chk("R4 issued after window", q.size(), 0);

        // R6 suspend
        expect_op(3'd4, '0, 8'h00, 8'h24);
        bus_write(18'h00000, 8'hB0, 1'b0);
        read_mode_at(18'h10004, "R6 erasing sector status", 2);
        read_mode_at(18'h00004, "R6 other sector array", 0);

        // R7 program while suspended
        unlock();
        bus_write(18'h00555, 8'hA0, 1'b0);
        expect_op(3'd1, 18'h00100, 8'h3C, '0);
        bus_write(18'h00100, 8'h3C, 1'b0);
        chk("R7 status during program", rd_mode, 2);
        done_pulse();
        read_mode_at(18'h00004, "R7 back to suspended array", 0);
        read_mode_at(18'h28004, "R7 back to suspended status", 2);
        unlock();
        bus_write(18'h00555, 8'hA0, 1'b0);
        bus_write(18'h28010, 8'h11, 1'b0);
        read_mode_at(18'h00004, "R7 rejected program", 0);

        // R6 resume
        expect_op(3'd5, '0, 8'h00, 8'h24);
        bus_write(18'h00000, 8'h30, 1'b0);
        read_mode_at(18'h00004, "R6 status after resume", 2);
        done_pulse();
        chk("R6 array after done", rd_mode, 0);

        // R10 cancel in window
        unlock();
        bus_write(18'h00555, 8'h80, 1'b0);
        unlock();
        bus_write(18'h08000, 8'h30, 1'b0);
        bus_write(18'h00000, 8'h00, 1'b0);
        repeat (200) @(negedge clk);
        chk("R10 cancelled", rd_mode, 0);

        // R12 reset during erase (part of R1)
        unlock();
        bus_write(18'h00555, 8'h80, 1'b0);
        unlock();
        expect_op(3'd2, '0, 8'h00, 8'hFF);
        bus_write(18'h00555, 8'h10, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 array after reset in erase", rd_mode, 0);
        done_pulse();
        bus_write(18'h00000, 8'hB0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R1 no request after reset", rd_mode, 0);

        repeat (5) @(negedge clk);
        chk("R2 scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule